// File: doc/BRIEF.md
# Segmented Word Stack Engine

This block runs 16-bit push and pop operations against a memory that is one byte wide. It holds two registers: a stack segment and a stack pointer. A 20-bit byte address is formed from them as segment × 16 + offset. The stack grows toward lower addresses in steps of two bytes. The pointer wraps inside its 64 KB segment, and the physical address wraps inside the 1 MB space. A push first moves the pointer down by two and then writes the word as two byte cycles. A pop reads the two bytes at the current pointer and then moves the pointer up by two.

Commands arrive on a single-cycle strobe with a two-bit opcode and a 16-bit operand. The opcodes are push, pop, segment load and pointer load. Memory traffic uses a request/ready handshake. A byte cycle completes on the clock edge where request and ready are both high. Loading the segment arms an interlock. Until the pointer is loaded, every other command is refused and no state changes. This keeps a stack from ever being addressed through a new segment paired with an old pointer.

Top module: `seg_stack_engine`

## Requirements
- R1: The byte address on `mem_addr` is (segment × 16 + offset) modulo 2^20. The offset is the pointer for the low byte and (pointer + 1) modulo 2^16 for the high byte.
- R2: A push (`cmd_op` = 2'b00) lowers the pointer by 2. It then writes bits [7:0] of the operand at the new pointer, followed by bits [15:8] at the new pointer + 1. The low byte always goes first.
- R3: A pop (`cmd_op` = 2'b01) reads the low byte at the pointer, then the high byte at pointer + 1. One cycle after the second byte completes, it presents {high, low} on `rsp_data` with a one-cycle `rsp_valid` pulse, and the pointer has risen by 2.
- R4: Pointer arithmetic is modulo 2^16. A push from pointer 0000h leaves FFFEh, and a pop from FFFEh leaves 0000h.
- R5: After a segment load (`cmd_op` = 2'b10), the only command accepted is a pointer load (`cmd_op` = 2'b11). Any other command raises `cmd_reject` for one cycle. It changes neither register and starts no memory cycle.
- R6: `busy` rises the cycle after a push or pop is accepted and falls after the last byte cycle completes. A command presented while `busy` is high is ignored and is not rejected.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R8: Segment and pointer loads take effect on the next cycle, are visible on `stk_seg` and `stk_ptr`, and neither raise `busy` nor touch memory.
- R9: After reset the segment and pointer are 0, the interlock is clear, and `busy`, `mem_req`, `rsp_valid` and `cmd_reject` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 push, 01 pop, 10 segment load, 11 pointer load |
| cmd_data | input | 16 | Push word or load value |
| busy | output | 1 | A push or pop is in progress |
| cmd_reject | output | 1 | One-cycle pulse when the interlock refuses a command |
| rsp_valid | output | 1 | One-cycle pulse marking pop data |
| rsp_data | output | 16 | Popped word |
| stk_seg | output | 16 | Current stack segment |
| stk_ptr | output | 16 | Current stack pointer |
| mem_req | output | 1 | Byte cycle request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Memory completes the byte cycle this edge |
| mem_rdata | input | 8 | Read byte, valid while `mem_ready` is high |

## Verification
Two events can land in the same cycle. One is a new command on the strobe. The other is the final byte completion of a push or pop, which clears `busy` and, for a pop, updates the pointer. The bench provokes this in two ways. It presents a segment load while a push is waiting on random memory wait states. It also presents commands back to back as soon as `busy` falls. The overlapping command must leave the segment unchanged and raise no reject, and the next accepted command must see the pointer that the finished operation left behind.

// File: rtl/ssk_pkg.sv
package ssk_pkg;

  typedef enum logic [1:0] {
    OP_PUSH  = 2'b00,
    OP_POP   = 2'b01,
    OP_LDSEG = 2'b10,
    OP_LDPTR = 2'b11
  } ssk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WR_LO = 3'd1,
    ST_WR_HI = 3'd2,
    ST_RD_LO = 3'd3,
    ST_RD_HI = 3'd4
  } ssk_state_e;

endpackage

// File: rtl/ssk_cmd_gate.sv
module ssk_cmd_gate
  import ssk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       busy,
  output logic       acc_push,
  output logic       acc_pop,
  output logic       acc_ldseg,
  output logic       acc_ldptr,
  output logic       lock_q,
  output logic       reject_q
);

  ssk_op_e op;
  logic    attempt;
  logic    blocked;

  assign op      = ssk_op_e'(cmd_op);
  // Commands are only considered while no word transfer is running.
  assign attempt = cmd_valid && !busy;
  // Interlock: after a segment load only a pointer load may pass.
  assign blocked = lock_q && (op != OP_LDPTR);

  assign acc_push  = attempt && !blocked && (op == OP_PUSH);
  assign acc_pop   = attempt && !blocked && (op == OP_POP);
  assign acc_ldseg = attempt && !blocked && (op == OP_LDSEG);
  assign acc_ldptr = attempt && !blocked && (op == OP_LDPTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= attempt && blocked;
      if (acc_ldseg)
        lock_q <= 1'b1;
      else if (acc_ldptr)
        lock_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ssk_ptr_regs.sv
module ssk_ptr_regs #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_ldseg,
  input  logic             acc_ldptr,
  input  logic             acc_push,
  input  logic             pop_done,
  input  logic [OFS_W-1:0] ld_value,
  output logic [SEG_W-1:0] seg_q,
  output logic [OFS_W-1:0] ptr_q
);

  localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP);

  // Pointer moves are modulo 2^OFS_W: the pointer never leaves its segment.
  function automatic logic [OFS_W-1:0] ptr_down(input logic [OFS_W-1:0] p);
    return p - STEP_V;
  endfunction

  function automatic logic [OFS_W-1:0] ptr_up(input logic [OFS_W-1:0] p);
    return p + STEP_V;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      ptr_q <= '0;
    end else begin
      if (acc_ldseg)
        seg_q <= SEG_W'(ld_value);
      // The four events below are mutually exclusive by the gate and busy.
      if (acc_ldptr)
        ptr_q <= ld_value;
      else if (acc_push)
        ptr_q <= ptr_down(ptr_q);
      else if (pop_done)
        ptr_q <= ptr_up(ptr_q);
    end
  end

endmodule

// File: rtl/ssk_addr_gen.sv
module ssk_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFS_W-1:0]  ptr,
  input  logic              hi_sel,
  output logic [OFS_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);

  localparam int SUM_W = ADDR_W + 1;

  // Offset of the byte within the segment, wrapping modulo 2^OFS_W.
  function automatic logic [OFS_W-1:0] byte_offset(input logic [OFS_W-1:0] p,
                                                   input logic hi);
    return p + OFS_W'(hi);
  endfunction

  // Physical address: segment scaled by 2^SEG_SHIFT plus offset, truncated.
  function automatic logic [ADDR_W-1:0] phys(input logic [SEG_W-1:0] s,
                                             input logic [OFS_W-1:0] o);
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;
    base = SUM_W'(s) << SEG_SHIFT;
    sum  = base + SUM_W'(o);
    return sum[ADDR_W-1:0];
  endfunction

  assign offset = byte_offset(ptr, hi_sel);
  assign addr   = phys(seg, offset);

endmodule

// File: rtl/ssk_byte_seq.sv
module ssk_byte_seq
  import ssk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_push,
  input  logic              acc_pop,
  input  logic [WORD_W-1:0] push_word,
  input  logic              mem_ready,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic              hi_sel,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              byte_done,
  output logic              pop_done,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);

  ssk_state_e        state_q;
  ssk_state_e        state_d;
  logic [WORD_W-1:0] wr_word_q;
  logic [BYTE_W-1:0] rd_lo_q;

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
  assign hi_sel    = (state_q == ST_WR_HI) || (state_q == ST_RD_HI);
  assign mem_wdata = hi_sel ? wr_word_q[WORD_W-1:BYTE_W] : wr_word_q[BYTE_W-1:0];
  assign byte_done = mem_req && mem_ready;
  assign pop_done  = byte_done && (state_q == ST_RD_HI);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (acc_push)
          state_d = ST_WR_LO;
        else if (acc_pop)
          state_d = ST_RD_LO;
      end
      ST_WR_LO: if (byte_done) state_d = ST_WR_HI;
      ST_WR_HI: if (byte_done) state_d = ST_IDLE;
      ST_RD_LO: if (byte_done) state_d = ST_RD_HI;
      ST_RD_HI: if (byte_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_word_q <= '0;
      rd_lo_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= pop_done;
      if (acc_push)
        wr_word_q <= push_word;
      if (byte_done && state_q == ST_RD_LO)
        rd_lo_q <= mem_rdata;
      if (pop_done)
        rsp_data <= join_bytes(mem_rdata, rd_lo_q);
    end
  end

endmodule

// File: rtl/seg_stack_engine.sv
module seg_stack_engine
  import ssk_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int WORD_W    = 2 * BYTE_W,
  parameter int ADDR_W    = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              busy,
  output logic              cmd_reject,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic [SEG_W-1:0]  stk_seg,
  output logic [OFS_W-1:0]  stk_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [BYTE_W-1:0] mem_rdata
);

  localparam int STEP = WORD_W / BYTE_W;

  // Named internal events, brought out for the checker.
  logic             ev_push;
  logic             ev_pop;
  logic             ev_ldseg;
  logic             ev_ldptr;
  logic             ev_byte_done;
  logic             ev_pop_done;
  logic             lock;
  logic             hi_sel;
  logic [OFS_W-1:0] byte_ofs;

  ssk_cmd_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .acc_push  (ev_push),
    .acc_pop   (ev_pop),
    .acc_ldseg (ev_ldseg),
    .acc_ldptr (ev_ldptr),
    .lock_q    (lock),
    .reject_q  (cmd_reject)
  );

  ssk_ptr_regs #(
    .SEG_W (SEG_W),
    .OFS_W (OFS_W),
    .STEP  (STEP)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_ldseg (ev_ldseg),
    .acc_ldptr (ev_ldptr),
    .acc_push  (ev_push),
    .pop_done  (ev_pop_done),
    .ld_value  (OFS_W'(cmd_data)),
    .seg_q     (stk_seg),
    .ptr_q     (stk_ptr)
  );

  ssk_byte_seq #(
    .BYTE_W (BYTE_W),
    .WORD_W (WORD_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_push  (ev_push),
    .acc_pop   (ev_pop),
    .push_word (cmd_data),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .hi_sel    (hi_sel),
    .mem_wdata (mem_wdata),
    .byte_done (ev_byte_done),
    .pop_done  (ev_pop_done),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  ssk_addr_gen #(
    .SEG_W     (SEG_W),
    .OFS_W     (OFS_W),
    .SEG_SHIFT (SEG_SHIFT),
    .ADDR_W    (ADDR_W)
  ) u_addr (
    .seg    (stk_seg),
    .ptr    (stk_ptr),
    .hi_sel (hi_sel),
    .offset (byte_ofs),
    .addr   (mem_addr)
  );

endmodule

// File: rtl/ssk_checker.sv
module ssk_checker #(
  parameter int BYTE_W = 8,
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              busy,
  input logic              cmd_reject,
  input logic              rsp_valid,
  input logic [SEG_W-1:0]  stk_seg,
  input logic [OFS_W-1:0]  stk_ptr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BYTE_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              ev_push,
  input logic              ev_ldseg,
  input logic              ev_ldptr,
  input logic              ev_pop_done,
  input logic              lock
);

  localparam logic [OFS_W-1:0] TWO = OFS_W'(2);

  // R2, R4: accepted push lowers the pointer by two, modulo 2^16
  a_r2_push_lowers_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> (stk_ptr == $past(stk_ptr) - TWO));

  // R3, R4: finished pop raises the pointer by two and pulses the response
  a_r3_pop_raises_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_done |=> (stk_ptr == $past(stk_ptr) + TWO) && rsp_valid);

  // R5: refused command pulses reject and changes nothing
  a_r5_reject_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && cmd_valid && !busy && cmd_op != 2'b11)
      |=> cmd_reject && !busy && $stable(stk_ptr) && $stable(stk_seg));

  // R6: commands during a transfer are ignored, never rejected
  a_r6_ignored_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> !cmd_reject && $stable(stk_seg));

  // R6: memory is only requested while busy
  a_r6_req_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R7: request holds steady while the memory stalls
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready)
      |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8: loads never start a transfer
  a_r8_load_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ldseg || ev_ldptr) |=> !busy);

  // R3: response pulse only once the transfer has ended
  a_r3_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

endmodule

bind seg_stack_engine ssk_checker #(
  .BYTE_W (BYTE_W),
  .SEG_W  (SEG_W),
  .OFS_W  (OFS_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .busy        (busy),
  .cmd_reject  (cmd_reject),
  .rsp_valid   (rsp_valid),
  .stk_seg     (stk_seg),
  .stk_ptr     (stk_ptr),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ready   (mem_ready),
  .ev_push     (ev_push),
  .ev_ldseg    (ev_ldseg),
  .ev_ldptr    (ev_ldptr),
  .ev_pop_done (ev_pop_done),
  .lock        (lock)
);

// File: tb/seg_stack_engine_tb_top.sv
`timescale 1ns/1ps
module seg_stack_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_data = '0;
  logic        busy, cmd_reject, rsp_valid;
  logic [15:0] rsp_data, stk_seg, stk_ptr;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ready = 1'b0;
  logic [7:0]  mem_rdata = '0;

  always #5 clk = ~clk;

  seg_stack_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .cmd_reject(cmd_reject),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .stk_seg(stk_seg),
    .stk_ptr(stk_ptr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model state
  logic [15:0] m_seg = '0;
  logic [15:0] m_ptr = '0;
  logic [7:0]  mem [int];
  int          w_addr [$];
  logic [7:0]  w_data [$];
  int          r_addr [$];
  int          rsp_cnt = 0;
  logic [15:0] rsp_last = '0;
  int          rej_cnt = 0;

  function automatic int b_phys(input logic [15:0] s, input logic [15:0] o);
    return (int'(s) * 16 + int'(o)) % 32'h100000;
  endfunction

  function automatic logic [7:0] b_fill(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] b_read(input int a);
    return mem.exists(a) ? mem[a] : b_fill(a);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model with random wait states
  always @(negedge clk) begin
    mem_ready <= mem_req && ($urandom_range(0, 3) != 0);
    mem_rdata <= b_read(int'(mem_addr));
  end

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[int'(mem_addr)] = mem_wdata;
        w_addr.push_back(int'(mem_addr));
        w_data.push_back(mem_wdata);
      end else begin
        r_addr.push_back(int'(mem_addr));
      end
    end
  end

  always @(negedge clk) begin
    if (rsp_valid) begin rsp_cnt++; rsp_last = rsp_data; end
    if (cmd_reject) rej_cnt++;
  end

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  // Presents one command for one cycle; returns at the negedge after acceptance.
  task automatic issue(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk);
    wait_idle();
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_load(input logic [1:0] op, input logic [15:0] v);
    issue(op, v);
    if (op == 2'b10) m_seg = v; else m_ptr = v;
    check(!busy && !mem_req, "R8 load no busy", busy, 0);
    check(stk_seg == m_seg, "R8 segment", stk_seg, m_seg);
    check(stk_ptr == m_ptr, "R8 pointer", stk_ptr, m_ptr);
  endtask

  task automatic do_push(input logic [15:0] d);
    logic [15:0] np;
    w_addr.delete(); w_data.delete();
    np = m_ptr - 16'd2;
    issue(2'b00, d);
    check(busy == 1'b1, "R6 busy after push", busy, 1);
    wait_idle();
    m_ptr = np;
    check(stk_ptr == m_ptr, "R2 R4 pointer after push", stk_ptr, m_ptr);
    check(w_addr.size() == 2, "R2 write count", w_addr.size(), 2);
    if (w_addr.size() == 2) begin
      check(w_addr[0] == b_phys(m_seg, np), "R1 R2 low addr", w_addr[0], b_phys(m_seg, np));
      check(w_data[0] == d[7:0], "R2 low byte first", w_data[0], d[7:0]);
      check(w_addr[1] == b_phys(m_seg, np + 16'd1), "R1 R2 high addr", w_addr[1], b_phys(m_seg, np + 16'd1));
      check(w_data[1] == d[15:8], "R2 high byte", w_data[1], d[15:8]);
    end
  endtask

  task automatic do_pop();
    int a0, a1, c0;
    logic [15:0] exp;
    a0 = b_phys(m_seg, m_ptr);
    a1 = b_phys(m_seg, m_ptr + 16'd1);
    exp = {b_read(a1), b_read(a0)};
    r_addr.delete();
    c0 = rsp_cnt;
    issue(2'b01, 16'h0000);
    check(busy == 1'b1, "R6 busy after pop", busy, 1);
    wait_idle();
    @(negedge clk);
    m_ptr = m_ptr + 16'd2;
    check(rsp_cnt == c0 + 1, "R3 one response", rsp_cnt - c0, 1);
    check(rsp_last == exp, "R3 pop data", rsp_last, exp);
    check(stk_ptr == m_ptr, "R3 R4 pointer after pop", stk_ptr, m_ptr);
    check(r_addr.size() == 2, "R3 read count", r_addr.size(), 2);
    if (r_addr.size() == 2) begin
      check(r_addr[0] == a0, "R1 R3 low read addr", r_addr[0], a0);
      check(r_addr[1] == a1, "R1 R3 high read addr", r_addr[1], a1);
    end
  endtask

  task automatic expect_reject(input logic [1:0] op, input string tag);
    int r0;
    r0 = rej_cnt;
    w_addr.delete(); r_addr.delete();
    issue(op, 16'h7777);
    check(cmd_reject == 1'b1, {"R5 reject pulse ", tag}, cmd_reject, 1);
    check(!busy, {"R5 no busy ", tag}, busy, 0);
    @(negedge clk);
    check(rej_cnt == r0 + 1, {"R5 single pulse ", tag}, rej_cnt - r0, 1);
    check(stk_seg == m_seg && stk_ptr == m_ptr, {"R5 state kept ", tag},
          {stk_seg, stk_ptr}, {m_seg, m_ptr});
    check(w_addr.size() + r_addr.size() == 0, {"R5 no memory ", tag},
          w_addr.size() + r_addr.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(stk_seg == 0 && stk_ptr == 0, "R9 reset regs", {stk_seg, stk_ptr}, 0);
    check(!busy && !mem_req && !rsp_valid && !cmd_reject, "R9 reset outputs",
          {busy, mem_req, rsp_valid, cmd_reject}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: interlock after a segment load
    do_load(2'b10, 16'h1000);
    expect_reject(2'b00, "push");
    expect_reject(2'b01, "pop");
    expect_reject(2'b10, "segload");
    do_load(2'b11, 16'h0000);

    // R4: first push from an empty 64 KB stack wraps to FFFE
    do_push(16'hA55A);
    check(stk_ptr == 16'hFFFE, "R4 wrap to FFFE", stk_ptr, 16'hFFFE);
    do_push(16'h1234);
    do_pop();
    check(rsp_last == 16'h1234, "R3 LIFO order", rsp_last, 16'h1234);
    do_pop();
    check(rsp_last == 16'hA55A && stk_ptr == 16'h0000, "R3 R4 back to empty",
          {rsp_last, stk_ptr}, {16'hA55A, 16'h0000});

    // R1: physical address wraps past the 1 MB top
    do_load(2'b10, 16'hFFFF);
    do_load(2'b11, 16'h0022);
    do_push(16'hBEEF);
    check(w_addr.size() == 2 && w_addr[0] == 32'h00010, "R1 20-bit wrap",
          w_addr.size() == 2 ? w_addr[0] : -1, 32'h00010);

    // R4: odd pointer, high byte offset wraps inside segment
    do_load(2'b10, 16'h2000);
    do_load(2'b11, 16'hFFFF);
    do_pop();
    check(r_addr.size() == 2 && r_addr[1] == 32'h20000, "R4 offset wrap on high byte",
          r_addr.size() == 2 ? r_addr[1] : -1, 32'h20000);

    // R6: a segment load during a push is ignored, not rejected
    begin
      int r0;
      r0 = rej_cnt;
      issue(2'b00, 16'hCAFE);
      m_ptr = m_ptr - 16'd2;
      cmd_valid = 1'b1; cmd_op = 2'b10; cmd_data = 16'h0BAD;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_idle();
      @(negedge clk);
      check(stk_seg == m_seg, "R6 ignored while busy", stk_seg, m_seg);
      check(rej_cnt == r0, "R6 no reject while busy", rej_cnt - r0, 0);
      check(stk_ptr == m_ptr, "R6 push completed", stk_ptr, m_ptr);
    end

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) begin
        do_load(2'b10, 16'($urandom));
        do_load(2'b11, 16'($urandom) & 16'hFFFE);
      end else if (r <= 5) begin
        do_push(16'($urandom));
      end else begin
        do_pop();
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule